// File: doc/BRIEF.md
# Source Operand Decode and Fetch

This block sits in the operand-read stage of a GPU-style execution pipeline. It takes a 9-bit source operand code and turns it into a 32-bit or 64-bit operand value. Each code selects one of several sources: a scalar register, a vector register or one of a few special registers. A code can also select a condition flag, an inline integer or floating-point constant, or the literal dword that trails the instruction.

The scalar and vector register files sit outside the block. It drives their read addresses from the code. Each file returns the word at that address and the word at the next address during the same cycle. The result is registered, so every operand code has the same one-cycle latency. Codes that are reserved, have no source in this block or name a misaligned register pair raise an illegal flag and give a zero value. A separate flag tells the fetch logic that the trailing literal dword was consumed.

For a 32-bit operand the upper half of the result is always zero. Two things depend on the operand width and on whether the instruction is scalar or vector: how an inline constant expands and how the literal is placed.

Top module: `srcop_fetch`

## Requirements
- R1: Each request sampled with `valid_i` high produces its result one clock later with `valid_o` high. A cycle with `valid_i` low gives `valid_o` low one clock later.
- R2: Codes 0 to 103 select scalar register n. At 64 bits the result is {reg n+1, reg n}. An odd code at 64 bits is illegal.
- R3: Codes 256 to 511 select vector register (code−256), at 64 bits as {reg n+1, reg n}. They are illegal in a scalar instruction, and vector register 255 is illegal at 64 bits.
- R4: Code 106 gives vector-carry bits 31:0 and code 107 gives bits 63:32. Code 126 gives exec-mask bits 31:0 and code 127 gives bits 63:32. Code 124 gives M0. At 64 bits, 106 and 126 give the full 64-bit register, while 107, 127 and 124 are illegal.
- R5: Code 128 gives 0, codes 129 to 192 give 1 to 64 and codes 193 to 208 give −1 to −16. The value is two's complement at the operand width, so at 64 bits it is sign-extended.
- R6: At 32 bits, codes 240 to 247 give single-precision 0.5, −0.5, 1.0, −1.0, 2.0, −2.0, 4.0 and −4.0. Code bit 0 is the sign. Code 248 gives 0x3E22F983, which is 1/(2π).
- R7: At 64 bits, codes 240 to 248 give the double-precision encoding of the same constants. For example, 242 gives 0x3FF0000000000000 and 248 gives 0x3FC45F306DC9C882.
- R8: Code 251 returns 1 when the vector-carry register is all zero. Code 252 returns 1 when the exec mask is all zero. Code 253 returns the scalar condition bit. In each case the flag sits in bit 0 and every other bit is zero.
- R9: Code 255 returns the literal dword and raises `lit_used_o`. No other code raises `lit_used_o`.
- R10: For a 64-bit operand with code 255, a scalar instruction gives the literal extended to 64 bits. The extension copies bit 31 when `lit_sext_i` is 1 and fills with zeros when it is 0. A vector instruction instead gives {literal, 32'h0}.
- R11: Codes 104, 105, 108 to 123, 125, 209 to 239, 249, 250 and 254 are illegal. Any illegal request raises `illegal_o`, gives a zero result and keeps `lit_used_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request valid |
| code_i | input | 9 | Source operand code |
| wide_i | input | 1 | 1 = 64-bit operand, 0 = 32-bit |
| vector_i | input | 1 | 1 = vector instruction, 0 = scalar |
| lit_sext_i | input | 1 | Sign-extend the literal for a 64-bit scalar operand |
| lit_i | input | 32 | Literal dword following the instruction |
| s_raddr_o | output | 7 | Scalar register file read address |
| s_rdata_lo_i | input | 32 | Scalar register at s_raddr_o |
| s_rdata_hi_i | input | 32 | Scalar register at s_raddr_o+1 |
| v_raddr_o | output | 8 | Vector register file read address |
| v_rdata_lo_i | input | 32 | Vector register at v_raddr_o |
| v_rdata_hi_i | input | 32 | Vector register at v_raddr_o+1 |
| vcc_i | input | 64 | Vector-carry register |
| exec_i | input | 64 | Execution mask |
| m0_i | input | 32 | M0 helper register |
| scc_i | input | 1 | Scalar condition bit |
| valid_o | output | 1 | Result valid |
| data_o | output | 64 | Operand value |
| illegal_o | output | 1 | Illegal operand |
| lit_used_o | output | 1 | Literal dword consumed |

## Verification
The assertions assume that the code, width and instruction-kind inputs are known whenever `valid_i` is high. They also assume that the register files answer within the same cycle the address is presented. The bench models both register files as combinational functions of the read addresses. It changes the special registers and the condition bit only in cycles where `valid_i` is low, so each captured request sees a single consistent set of side inputs.

// File: rtl/srcop_pkg.sv
package srcop_pkg;
   typedef enum logic [3:0] {
      K_NONE, K_SREG, K_VREG, K_VCC, K_M0, K_EXEC, K_INT, K_FLT, K_FLAG, K_LIT
   } src_kind_e;

   localparam int CODE_W     = 9;
   localparam int C_VCC_LO   = 106;
   localparam int C_VCC_HI   = 107;
   localparam int C_M0       = 124;
   localparam int C_EXEC_LO  = 126;
   localparam int C_EXEC_HI  = 127;
   localparam int C_INT_ZERO = 128;
   localparam int C_INT_POS  = 192;
   localparam int C_INT_NEG  = 208;
   localparam int C_FLT_FIRST = 240;
   localparam int C_INV2PI   = 248;
   localparam int C_VCCZ     = 251;
   localparam int C_EXECZ    = 252;
   localparam int C_SCC      = 253;
   localparam int C_LITERAL  = 255;
   localparam int C_VREG_BASE = 256;
endpackage

// File: rtl/srcop_classify.sv
module srcop_classify
   import srcop_pkg::*;
#(
   parameter int SGPR_COUNT = 104,
   parameter int VGPR_COUNT = 256
) (
   input  logic [CODE_W-1:0] code_i,
   input  logic              wide_i,
   input  logic              vector_i,
   output src_kind_e         kind_o,
   output logic              illegal_o
);
   int  code_n;
   logic vreg_oob;

   assign code_n = int'(code_i);

   generate
      if (VGPR_COUNT < 256) begin : g_vbound
         assign vreg_oob = int'(code_i[7:0]) >= VGPR_COUNT;
      end else begin : g_vfull
         assign vreg_oob = 1'b0;
      end
   endgenerate

   always_comb begin
      kind_o    = K_NONE;
      illegal_o = 1'b1;
      if (code_n >= C_VREG_BASE) begin
         kind_o    = K_VREG;
         illegal_o = !vector_i || vreg_oob ||
                     (wide_i && int'(code_i[7:0]) == VGPR_COUNT - 1);
      end else if (code_n < SGPR_COUNT) begin
         kind_o    = K_SREG;
         illegal_o = wide_i && code_i[0];
      end else if (code_n == C_VCC_LO || code_n == C_VCC_HI) begin
         kind_o    = K_VCC;
         illegal_o = wide_i && code_i[0];
      end else if (code_n == C_EXEC_LO || code_n == C_EXEC_HI) begin
         kind_o    = K_EXEC;
         illegal_o = wide_i && code_i[0];
      end else if (code_n == C_M0) begin
         kind_o    = K_M0;
         illegal_o = wide_i;
      end else if (code_n >= C_INT_ZERO && code_n <= C_INT_NEG) begin
         kind_o    = K_INT;
         illegal_o = 1'b0;
      end else if (code_n >= C_FLT_FIRST && code_n <= C_INV2PI) begin
         kind_o    = K_FLT;
         illegal_o = 1'b0;
      end else if (code_n >= C_VCCZ && code_n <= C_SCC) begin
         kind_o    = K_FLAG;
         illegal_o = 1'b0;
      end else if (code_n == C_LITERAL) begin
         kind_o    = K_LIT;
         illegal_o = 1'b0;
      end
   end
endmodule

// File: rtl/srcop_const.sv
module srcop_const
   import srcop_pkg::*;
(
   input  logic [CODE_W-1:0] code_i,
   input  logic              wide_i,
   output logic [63:0]       int_o,
   output logic [63:0]       flt_o
);
   localparam logic [31:0] INV2PI_SP = 32'h3E22_F983;
   localparam logic [63:0] INV2PI_DP = 64'h3FC4_5F30_6DC9_C882;

   logic [1:0]  mag;
   logic        sgn;
   logic [7:0]  exp_sp;
   logic [10:0] exp_dp;

   assign mag    = code_i[2:1];
   assign sgn    = code_i[0];
   assign exp_sp = 8'd126 + {6'd0, mag};
   assign exp_dp = 11'd1022 + {9'd0, mag};

   always_comb begin
      if (int'(code_i) <= C_INT_POS)
         int_o = 64'(int'(code_i) - C_INT_ZERO);
      else
         int_o = 64'(C_INT_POS - int'(code_i));
   end

   always_comb begin
      if (int'(code_i) == C_INV2PI)
         flt_o = wide_i ? INV2PI_DP : {32'd0, INV2PI_SP};
      else if (wide_i)
         flt_o = {sgn, exp_dp, 52'd0};
      else
         flt_o = {32'd0, sgn, exp_sp, 23'd0};
   end
endmodule

// File: rtl/srcop_fetch.sv
module srcop_fetch
   import srcop_pkg::*;
#(
   parameter int SGPR_COUNT = 104,
   parameter int VGPR_COUNT = 256,
   parameter int DW         = 32,
   localparam int SAW       = $clog2(SGPR_COUNT),
   localparam int VAW       = $clog2(VGPR_COUNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              wide_i,
   input  logic              vector_i,
   input  logic              lit_sext_i,
   input  logic [DW-1:0]     lit_i,
   output logic [SAW-1:0]    s_raddr_o,
   input  logic [DW-1:0]     s_rdata_lo_i,
   input  logic [DW-1:0]     s_rdata_hi_i,
   output logic [VAW-1:0]    v_raddr_o,
   input  logic [DW-1:0]     v_rdata_lo_i,
   input  logic [DW-1:0]     v_rdata_hi_i,
   input  logic [2*DW-1:0]   vcc_i,
   input  logic [2*DW-1:0]   exec_i,
   input  logic [DW-1:0]     m0_i,
   input  logic              scc_i,
   output logic              valid_o,
   output logic [2*DW-1:0]   data_o,
   output logic              illegal_o,
   output logic              lit_used_o
);
   localparam int QW = 2 * DW;

   generate
      if (DW != 32) begin : g_bad_dw
         $error("srcop_fetch: DW must be 32");
      end
      if (SGPR_COUNT < 2 || SGPR_COUNT > 104) begin : g_bad_sgpr
         $error("srcop_fetch: SGPR_COUNT out of range");
      end
      if (VGPR_COUNT < 2 || VGPR_COUNT > 256) begin : g_bad_vgpr
         $error("srcop_fetch: VGPR_COUNT out of range");
      end
   endgenerate

   src_kind_e kind;
   logic      bad;
   logic [63:0] int_val, flt_val;
   logic [QW-1:0] raw, nxt;

   srcop_classify #(.SGPR_COUNT(SGPR_COUNT), .VGPR_COUNT(VGPR_COUNT)) u_cls (
      .code_i   (code_i),
      .wide_i   (wide_i),
      .vector_i (vector_i),
      .kind_o   (kind),
      .illegal_o(bad)
   );

   srcop_const u_const (
      .code_i(code_i),
      .wide_i(wide_i),
      .int_o (int_val),
      .flt_o (flt_val)
   );

   assign s_raddr_o = code_i[SAW-1:0];
   assign v_raddr_o = code_i[VAW-1:0];

   always_comb begin
      unique case (kind)
         K_SREG:  raw = {s_rdata_hi_i, s_rdata_lo_i};
         K_VREG:  raw = {v_rdata_hi_i, v_rdata_lo_i};
         K_VCC:   raw = wide_i ? vcc_i
                      : {{DW{1'b0}}, code_i[0] ? vcc_i[QW-1:DW] : vcc_i[DW-1:0]};
         K_EXEC:  raw = wide_i ? exec_i
                      : {{DW{1'b0}}, code_i[0] ? exec_i[QW-1:DW] : exec_i[DW-1:0]};
         K_M0:    raw = {{DW{1'b0}}, m0_i};
         K_INT:   raw = int_val;
         K_FLT:   raw = flt_val;
         K_FLAG: begin
            raw = '0;
            if (int'(code_i) == C_VCCZ)       raw[0] = ~|vcc_i;
            else if (int'(code_i) == C_EXECZ) raw[0] = ~|exec_i;
            else                              raw[0] = scc_i;
         end
         K_LIT: begin
            if (!wide_i)       raw = {{DW{1'b0}}, lit_i};
            else if (vector_i) raw = {lit_i, {DW{1'b0}}};
            else               raw = {{DW{lit_sext_i & lit_i[DW-1]}}, lit_i};
         end
         default: raw = '0;
      endcase
      if (bad)
         nxt = '0;
      else if (!wide_i)
         nxt = {{DW{1'b0}}, raw[DW-1:0]};
      else
         nxt = raw;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o    <= 1'b0;
         data_o     <= '0;
         illegal_o  <= 1'b0;
         lit_used_o <= 1'b0;
      end else begin
         valid_o <= valid_i;
         if (valid_i) begin
            data_o     <= nxt;
            illegal_o  <= bad;
            lit_used_o <= (kind == K_LIT) && !bad;
         end
      end
   end
endmodule

// File: rtl/srcop_fetch_chk.sv
module srcop_fetch_chk #(
   parameter int SGPR_COUNT = 104
) (
   input logic        clk,
   input logic        rst_n,
   input logic        valid_i,
   input logic [8:0]  code_i,
   input logic        wide_i,
   input logic        vector_i,
   input logic        valid_o,
   input logic [63:0] data_o,
   input logic        illegal_o,
   input logic        lit_used_o
);
   // R1: fixed one-cycle latency
   p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> valid_o);
   p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> !valid_o);
   // R2: odd scalar start for a pair
   p_sreg_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && wide_i && int'(code_i) < SGPR_COUNT && code_i[0]) |=> illegal_o);
   // R3: vector code in scalar instruction
   p_vreg_scalar_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && code_i[8] && !vector_i) |=> illegal_o);
   // R5: zero constant
   p_zero_const_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && code_i == 9'd128) |=> (data_o == 64'd0 && !illegal_o));
   // R6: narrow float constant keeps upper half clear
   p_flt_narrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && !wide_i && code_i >= 9'd240 && code_i <= 9'd248)
         |=> (data_o[63:32] == 32'd0 && !illegal_o));
   // R9: literal flag follows literal code
   p_lit_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && code_i == 9'd255) |=> lit_used_o);
   p_lit_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && code_i != 9'd255) |=> !lit_used_o);
   // R11: reserved range and illegal result is zero
   p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && code_i >= 9'd209 && code_i <= 9'd239) |=> illegal_o);
   p_illegal_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && illegal_o) |-> (data_o == 64'd0 && !lit_used_o));
endmodule

bind srcop_fetch srcop_fetch_chk #(.SGPR_COUNT(SGPR_COUNT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .valid_i   (valid_i),
   .code_i    (code_i),
   .wide_i    (wide_i),
   .vector_i  (vector_i),
   .valid_o   (valid_o),
   .data_o    (data_o),
   .illegal_o (illegal_o),
   .lit_used_o(lit_used_o)
);

// File: tb/srcop_fetch_test.sv
module srcop_fetch_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_i = 1'b0;
   logic [8:0]  code_i = '0;
   logic        wide_i = 1'b0;
   logic        vector_i = 1'b0;
   logic        lit_sext_i = 1'b0;
   logic [31:0] lit_i = 32'h8000_0007;
   logic [6:0]  s_raddr;
   logic [7:0]  v_raddr;
   logic [31:0] s_lo, s_hi, v_lo, v_hi;
   logic [63:0] vcc_i  = 64'h1234_5678_9ABC_DEF0;
   logic [63:0] exec_i = 64'hFFFF_0000_0000_FFFF;
   logic [31:0] m0_i   = 32'h0001_0042;
   logic        scc_i  = 1'b1;
   logic        valid_o, illegal_o, lit_used_o;
   logic [63:0] data_o;

   typedef struct {
      logic [8:0]  code;
      logic [63:0] data;
      logic        ill;
      logic        lit;
      string       tag;
   } exp_t;
   exp_t sb[$];
   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   function automatic logic [31:0] sreg(input logic [6:0] a);
      return 32'h5A00_0000 | {25'd0, a};
   endfunction
   function automatic logic [31:0] vreg(input logic [7:0] a);
      return 32'hC0DE_0000 | {24'd0, a};
   endfunction

   assign s_lo = sreg(s_raddr);
   assign s_hi = sreg(s_raddr + 7'd1);
   assign v_lo = vreg(v_raddr);
   assign v_hi = vreg(v_raddr + 8'd1);

   srcop_fetch uut (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .code_i(code_i),
      .wide_i(wide_i), .vector_i(vector_i), .lit_sext_i(lit_sext_i),
      .lit_i(lit_i), .s_raddr_o(s_raddr), .s_rdata_lo_i(s_lo),
      .s_rdata_hi_i(s_hi), .v_raddr_o(v_raddr), .v_rdata_lo_i(v_lo),
      .v_rdata_hi_i(v_hi), .vcc_i(vcc_i), .exec_i(exec_i), .m0_i(m0_i),
      .scc_i(scc_i), .valid_o(valid_o), .data_o(data_o),
      .illegal_o(illegal_o), .lit_used_o(lit_used_o)
   );

   task automatic apply(input logic [8:0] c, input logic w, input logic v,
                        input logic sx, input logic [63:0] ed,
                        input logic eill, input logic elit, input string tag);
      exp_t e;
      @(negedge clk);
      code_i = c; wide_i = w; vector_i = v; lit_sext_i = sx; valid_i = 1'b1;
      e.code = c; e.data = ed; e.ill = eill; e.lit = elit; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic pause();
      @(negedge clk);
      valid_i = 1'b0;
   endtask

   // monitor: pop one expected item per valid result
   always @(negedge clk) begin
      if (rst_n && valid_o) begin
         checks++;
         if (sb.size() == 0) begin
            fails++;
            $display("FAIL R1 unexpected result: valid_o=1 expected=0");
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (data_o !== e.data || illegal_o !== e.ill || lit_used_o !== e.lit) begin
               fails++;
               $display("FAIL %s code=%0d actual data=%h ill=%b lit=%b expected data=%h ill=%b lit=%b",
                        e.tag, e.code, data_o, illegal_o, lit_used_o, e.data, e.ill, e.lit);
            end
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (valid_o !== 1'b0 || data_o !== 64'd0 || illegal_o !== 1'b0 || lit_used_o !== 1'b0) begin
         fails++;
         $display("FAIL R1 reset state: actual v=%b d=%h expected v=0 d=0", valid_o, data_o);
      end
      rst_n = 1'b1;
      // R2 scalar registers
      apply(9'd5,   0, 0, 0, 64'h0000_0000_5A00_0005, 0, 0, "R2");
      apply(9'd10,  1, 0, 0, 64'h5A00_000B_5A00_000A, 0, 0, "R2");
      apply(9'd11,  1, 0, 0, 64'd0, 1, 0, "R2");
      apply(9'd103, 0, 0, 0, 64'h0000_0000_5A00_0067, 0, 0, "R2");
      // R3 vector registers
      apply(9'd300, 0, 1, 0, 64'h0000_0000_C0DE_002C, 0, 0, "R3");
      apply(9'd300, 1, 1, 0, 64'hC0DE_002D_C0DE_002C, 0, 0, "R3");
      apply(9'd300, 0, 0, 0, 64'd0, 1, 0, "R3");
      apply(9'd511, 1, 1, 0, 64'd0, 1, 0, "R3");
      apply(9'd511, 0, 1, 0, 64'h0000_0000_C0DE_00FF, 0, 0, "R3");
      // R4 special registers
      apply(9'd106, 0, 0, 0, 64'h0000_0000_9ABC_DEF0, 0, 0, "R4");
      apply(9'd107, 0, 0, 0, 64'h0000_0000_1234_5678, 0, 0, "R4");
      apply(9'd106, 1, 0, 0, 64'h1234_5678_9ABC_DEF0, 0, 0, "R4");
      apply(9'd107, 1, 0, 0, 64'd0, 1, 0, "R4");
      apply(9'd124, 0, 0, 0, 64'h0000_0000_0001_0042, 0, 0, "R4");
      apply(9'd124, 1, 0, 0, 64'd0, 1, 0, "R4");
      apply(9'd127, 0, 0, 0, 64'h0000_0000_FFFF_0000, 0, 0, "R4");
      apply(9'd126, 1, 1, 0, 64'hFFFF_0000_0000_FFFF, 0, 0, "R4");
      // R5 integer constants
      apply(9'd128, 1, 0, 0, 64'd0, 0, 0, "R5");
      apply(9'd129, 0, 0, 0, 64'd1, 0, 0, "R5");
      apply(9'd192, 1, 1, 0, 64'd64, 0, 0, "R5");
      apply(9'd193, 0, 0, 0, 64'h0000_0000_FFFF_FFFF, 0, 0, "R5");
      apply(9'd208, 0, 1, 0, 64'h0000_0000_FFFF_FFF0, 0, 0, "R5");
      apply(9'd208, 1, 0, 0, 64'hFFFF_FFFF_FFFF_FFF0, 0, 0, "R5");
      // R6 single-precision constants
      apply(9'd240, 0, 0, 0, 64'h0000_0000_3F00_0000, 0, 0, "R6");
      apply(9'd243, 0, 1, 0, 64'h0000_0000_BF80_0000, 0, 0, "R6");
      apply(9'd247, 0, 0, 0, 64'h0000_0000_C080_0000, 0, 0, "R6");
      apply(9'd248, 0, 1, 0, 64'h0000_0000_3E22_F983, 0, 0, "R6");
      // R7 double-precision constants
      apply(9'd242, 1, 1, 0, 64'h3FF0_0000_0000_0000, 0, 0, "R7");
      apply(9'd245, 1, 0, 0, 64'hC000_0000_0000_0000, 0, 0, "R7");
      apply(9'd241, 1, 1, 0, 64'hBFE0_0000_0000_0000, 0, 0, "R7");
      apply(9'd248, 1, 1, 0, 64'h3FC4_5F30_6DC9_C882, 0, 0, "R7");
      // R8 flags, nonzero registers
      apply(9'd251, 0, 0, 0, 64'd0, 0, 0, "R8");
      apply(9'd252, 0, 0, 0, 64'd0, 0, 0, "R8");
      apply(9'd253, 1, 0, 0, 64'd1, 0, 0, "R8");
      pause();
      vcc_i = 64'd0; exec_i = 64'd0; scc_i = 1'b0;
      apply(9'd251, 0, 1, 0, 64'd1, 0, 0, "R8");
      apply(9'd252, 1, 1, 0, 64'd1, 0, 0, "R8");
      apply(9'd253, 0, 0, 0, 64'd0, 0, 0, "R8");
      // R9 literal at 32 bits
      apply(9'd255, 0, 0, 1, 64'h0000_0000_8000_0007, 0, 1, "R9");
      apply(9'd255, 0, 1, 0, 64'h0000_0000_8000_0007, 0, 1, "R9");
      // R10 literal at 64 bits
      apply(9'd255, 1, 0, 1, 64'hFFFF_FFFF_8000_0007, 0, 1, "R10");
      apply(9'd255, 1, 0, 0, 64'h0000_0000_8000_0007, 0, 1, "R10");
      apply(9'd255, 1, 1, 1, 64'h8000_0007_0000_0000, 0, 1, "R10");
      // R11 illegal codes
      apply(9'd104, 0, 0, 0, 64'd0, 1, 0, "R11");
      apply(9'd120, 0, 1, 0, 64'd0, 1, 0, "R11");
      apply(9'd125, 0, 0, 0, 64'd0, 1, 0, "R11");
      apply(9'd209, 1, 0, 0, 64'd0, 1, 0, "R11");
      apply(9'd239, 0, 1, 0, 64'd0, 1, 0, "R11");
      apply(9'd249, 0, 0, 0, 64'd0, 1, 0, "R11");
      apply(9'd254, 1, 1, 0, 64'd0, 1, 0, "R11");
      pause();
      repeat (3) @(negedge clk);
      // R1: every request answered, idle gives no result
      checks++;
      if (sb.size() != 0 || valid_o !== 1'b0) begin
         fails++;
         $display("FAIL R1 drain: actual pending=%0d valid_o=%b expected pending=0 valid_o=0",
                  sb.size(), valid_o);
      end
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule